// File: doc/BRIEF.md
# Clock Parameter-RAM Command Engine

This block is the byte-level command interpreter of a real-time clock. It keeps 256 bytes of parameter RAM, a four-byte image of the seconds counter and a write-lock register. It also accepts writes to a test register and stores nothing from them. A host hands it one byte at a time. The engine reports one of three outcomes for each byte: a data byte, a request for more bytes, or the end of a transaction with nothing to return.

Commands come in three lengths. A short command addresses a seconds byte, RAM 0x00–0x0F, RAM 0x10–0x13 or one of the two write-only registers. An extended command carries an 8-bit RAM address split over two bytes. Any write is followed by one more byte, which holds the data.

A small parallel front end drives the engine. It has a data register and a control register. A control write with the start bit set passes the data register to the engine, and the engine's result lands back in the data register. The start bit drops on the cycle after that.

Top module: `rtc_pram_ctrl`

## Requirements
- R1: Synchronous reset sets `ctrl_q` and `data_q` to 0x00, drops `eng_valid`, puts the engine in the command phase and clears the write lock. RAM and seconds contents are not cleared.
- R2: A control write with bit 7 clear leaves `ctrl_q` unchanged and does not strobe the engine. So does any control write while `ctrl_q[7]` is set.
- R3: A control write with bit 7 set and bit 6 clear is an accepted start.
  - Edge 1: `ctrl_q` takes the written value and the engine takes the byte in `data_q`.
  - After edge 1: `eng_valid` is high and `eng_status` carries the outcome. The codes are 00 for data, 01 for more bytes needed and 10 for complete with no data.
  - Edge 2: `data_q` takes the result byte, which is 0x00 for outcomes 01 and 10. `ctrl_q[7]` clears and the other control bits are kept.
- R4: A control write with bits 7:6 = 11 sets `ctrl_q`, gives no engine strobe, and leaves `data_q` unchanged. Bit 7 clears on the next edge.
- R5: Command bit 7 = 1 means read and 0 means write. A write command to a storable target answers 01, and the next byte is stored with answer 10.
- R6: With command bits 6:4 = 000, the command addresses seconds byte number bits 3:2.
- R7: With command bits 6:4 = 010, the command addresses RAM 0x10 + bits 3:2.
- R8: With command bit 6 = 1, the command addresses RAM at bits 5:2.
- R9: Command bits 6:3 = 0111 start an extended access. Bits 2:0 become address bits 7:5 and the engine answers 01. The second byte's bits 6:2 give address bits 4:0. A read then answers 00 with the RAM byte and returns to the command phase. A write answers 01 and waits for data.
- R10: A second address byte with any of bits 7, 1 or 0 set answers 10, and the engine returns to the command phase.
- R11: With command bits 6:3 = 0110, bit 2 selects the lock register (1) or the test register (0). Reading either answers 10. A write to either takes one data byte and answers 10.
- R12: A command with bits 6:4 = 001 answers 10 at once, and the engine stays in the command phase.
- R13: When the write lock (bit 7 of the last value written to the lock register) is set, writes to RAM and to the seconds bytes are dropped but still answer 10. Writes to the lock register are always accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| data_wr | input | 1 | Load `data_wdata` into the data register |
| data_wdata | input | 8 | Host value for the data register |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Host value for the control register |
| data_q | output | 8 | Data register |
| ctrl_q | output | 8 | Control register; bit 7 is the busy/start bit |
| eng_valid | output | 1 | Engine outcome valid |
| eng_status | output | 2 | Engine outcome code |

## Verification
The bench uses the default sizes: 256 RAM bytes, four seconds bytes and 8-bit commands. These are small enough to write and read back every RAM address through the extended form. The bench also reaches every short RAM and seconds address, and every command in the unrecognised group with both directions. Lock gating is tested on all three storage paths. The same run checks that the lock register itself stays writable while the lock is set.

// File: rtl/rtc_cmd_pkg.sv
package rtc_cmd_pkg;

    localparam int BYTE_W    = 8;
    localparam int RAM_AW    = 8;
    localparam int SEC_N     = 4;
    localparam int SEC_AW    = $clog2(SEC_N);
    localparam int EXT_HI_W  = 3;
    localparam int EXT_LO_W  = RAM_AW - EXT_HI_W;

    typedef enum logic [1:0] {
        PH_CMD    = 2'd0,
        PH_EXT_RD = 2'd1,
        PH_EXT_WR = 2'd2,
        PH_WDATA  = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        ST_DATA = 2'b00,
        ST_MORE = 2'b01,
        ST_DONE = 2'b10
    } status_e;

    typedef enum logic [2:0] {
        T_SEC, T_RAM, T_EXT, T_LOCK, T_TEST, T_BAD
    } target_e;

    typedef struct packed {
        logic              rd;
        target_e           tgt;
        logic [RAM_AW-1:0] addr;
    } cmd_dec_t;

    // Classify a first command byte.
    function automatic cmd_dec_t decode_cmd(input logic [BYTE_W-1:0] c);
        cmd_dec_t d;
        d.rd   = c[7];
        d.tgt  = T_BAD;
        d.addr = '0;
        if (c[6]) begin
            d.tgt  = T_RAM;
            d.addr = RAM_AW'(c[5:2]);
        end else begin
            case (c[5:4])
                2'b00: begin
                    d.tgt  = T_SEC;
                    d.addr = RAM_AW'(c[3:2]);
                end
                2'b10: begin
                    d.tgt  = T_RAM;
                    d.addr = RAM_AW'(8'h10) | RAM_AW'(c[3:2]);
                end
                2'b11: begin
                    if (c[3]) begin
                        d.tgt  = T_EXT;
                        d.addr = {c[EXT_HI_W-1:0], {EXT_LO_W{1'b0}}};
                    end else begin
                        d.tgt = c[2] ? T_LOCK : T_TEST;
                    end
                end
                default: d.tgt = T_BAD;
            endcase
        end
        return d;
    endfunction

    // Second address byte must keep bits 7, 1 and 0 clear.
    function automatic logic ext_lo_ok(input logic [BYTE_W-1:0] b);
        return !(b[7] || b[1] || b[0]);
    endfunction

endpackage

// File: rtl/rtc_store.sv
module rtc_store #(
    parameter int DW    = 8,
    parameter int AW    = 8,
    parameter int SEC_N = 4
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic          wr_sec,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_sec,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;
    localparam int SAW   = $clog2(SEC_N);

    logic [DW-1:0] ram   [DEPTH];
    logic [DW-1:0] sec_q [SEC_N];

    always_ff @(posedge clk) begin
        if (wr_en && !wr_sec) ram[wr_addr] <= wr_data;
    end

    for (genvar i = 0; i < SEC_N; i++) begin : g_sec
        always_ff @(posedge clk) begin
            if (wr_en && wr_sec && wr_addr[SAW-1:0] == SAW'(i))
                sec_q[i] <= wr_data;
        end
    end

    assign rd_data = rd_sec ? sec_q[rd_addr[SAW-1:0]] : ram[rd_addr];

endmodule

// File: rtl/rtc_cmd_engine.sv
module rtc_cmd_engine
    import rtc_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_vld,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              out_vld,
    output status_e           out_status,
    output logic [BYTE_W-1:0] out_byte,
    output logic              st_wr_en,
    output logic              st_wr_sec,
    output logic [RAM_AW-1:0] st_wr_addr,
    output logic [BYTE_W-1:0] st_wr_data,
    output logic              st_rd_sec,
    output logic [RAM_AW-1:0] st_rd_addr,
    input  logic [BYTE_W-1:0] st_rd_data
);
    phase_e            phase_q, phase_d;
    target_e           tgt_q, tgt_d;
    logic [RAM_AW-1:0] addr_q, addr_d;
    logic              lock_q;
    logic              lock_we;
    status_e           resp_st;
    logic [BYTE_W-1:0] resp_byte;
    cmd_dec_t          dec;
    logic [RAM_AW-1:0] ext_addr;

    assign dec      = decode_cmd(in_byte);
    assign ext_addr = {addr_q[RAM_AW-1:EXT_LO_W], in_byte[EXT_LO_W+1:2]};

    assign st_rd_sec  = (phase_q == PH_CMD) && (dec.tgt == T_SEC);
    assign st_rd_addr = (phase_q == PH_CMD) ? dec.addr : ext_addr;
    assign st_wr_addr = addr_q;
    assign st_wr_data = in_byte;
    assign st_wr_sec  = (tgt_q == T_SEC);

    always_comb begin
        phase_d   = phase_q;
        tgt_d     = tgt_q;
        addr_d    = addr_q;
        lock_we   = 1'b0;
        st_wr_en  = 1'b0;
        resp_st   = ST_DONE;
        resp_byte = '0;
        if (in_vld) begin
            case (phase_q)
                PH_CMD: begin
                    case (dec.tgt)
                        T_BAD: resp_st = ST_DONE;
                        T_EXT: begin
                            addr_d  = dec.addr;
                            tgt_d   = T_RAM;
                            phase_d = dec.rd ? PH_EXT_RD : PH_EXT_WR;
                            resp_st = ST_MORE;
                        end
                        T_LOCK, T_TEST: begin
                            if (!dec.rd) begin
                                tgt_d   = dec.tgt;
                                phase_d = PH_WDATA;
                                resp_st = ST_MORE;
                            end
                        end
                        default: begin
                            if (dec.rd) begin
                                resp_st   = ST_DATA;
                                resp_byte = st_rd_data;
                            end else begin
                                tgt_d   = dec.tgt;
                                addr_d  = dec.addr;
                                phase_d = PH_WDATA;
                                resp_st = ST_MORE;
                            end
                        end
                    endcase
                end
                PH_EXT_RD, PH_EXT_WR: begin
                    if (!ext_lo_ok(in_byte)) begin
                        phase_d = PH_CMD;
                        resp_st = ST_DONE;
                    end else if (phase_q == PH_EXT_RD) begin
                        phase_d   = PH_CMD;
                        resp_st   = ST_DATA;
                        resp_byte = st_rd_data;
                    end else begin
                        addr_d  = ext_addr;
                        phase_d = PH_WDATA;
                        resp_st = ST_MORE;
                    end
                end
                default: begin
                    phase_d = PH_CMD;
                    resp_st = ST_DONE;
                    case (tgt_q)
                        T_LOCK:  lock_we  = 1'b1;
                        T_TEST:  st_wr_en = 1'b0;
                        default: st_wr_en = !lock_q;
                    endcase
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q    <= PH_CMD;
            tgt_q      <= T_BAD;
            addr_q     <= '0;
            lock_q     <= 1'b0;
            out_vld    <= 1'b0;
            out_status <= ST_DONE;
            out_byte   <= '0;
        end else begin
            phase_q    <= phase_d;
            tgt_q      <= tgt_d;
            addr_q     <= addr_d;
            if (lock_we) lock_q <= in_byte[7];
            out_vld    <= in_vld;
            out_status <= resp_st;
            out_byte   <= resp_byte;
        end
    end

endmodule

// File: rtl/rtc_pram_ctrl.sv
module rtc_pram_ctrl
    import rtc_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       data_wr,
    input  logic [7:0] data_wdata,
    input  logic       ctrl_wr,
    input  logic [7:0] ctrl_wdata,
    output logic [7:0] data_q,
    output logic [7:0] ctrl_q,
    output logic       eng_valid,
    output logic [1:0] eng_status
);
    logic              start_ok;
    logic              eng_go;
    status_e           eng_st;
    logic [BYTE_W-1:0] eng_byte;
    logic              wr_en, wr_sec, rd_sec;
    logic [RAM_AW-1:0] wr_addr, rd_addr;
    logic [BYTE_W-1:0] wr_data, rd_data;

    assign start_ok   = ctrl_wr && ctrl_wdata[7] && !ctrl_q[7];
    assign eng_go     = start_ok && !ctrl_wdata[6];
    assign eng_status = eng_st;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            data_q <= '0;
        end else begin
            if (start_ok)       ctrl_q    <= ctrl_wdata;
            else if (ctrl_q[7]) ctrl_q[7] <= 1'b0;
            if (eng_valid)      data_q    <= eng_byte;
            else if (data_wr)   data_q    <= data_wdata;
        end
    end

    rtc_cmd_engine u_engine (
        .clk        (clk),
        .rst        (rst),
        .in_vld     (eng_go),
        .in_byte    (data_q),
        .out_vld    (eng_valid),
        .out_status (eng_st),
        .out_byte   (eng_byte),
        .st_wr_en   (wr_en),
        .st_wr_sec  (wr_sec),
        .st_wr_addr (wr_addr),
        .st_wr_data (wr_data),
        .st_rd_sec  (rd_sec),
        .st_rd_addr (rd_addr),
        .st_rd_data (rd_data)
    );

    rtc_store #(
        .DW    (BYTE_W),
        .AW    (RAM_AW),
        .SEC_N (SEC_N)
    ) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_sec  (wr_sec),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_sec  (rd_sec),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/rtc_pram_ctrl_chk.sv
module rtc_pram_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       ctrl_wr,
    input logic [7:0] ctrl_wdata,
    input logic [7:0] ctrl_q,
    input logic [7:0] data_q,
    input logic       eng_valid,
    input logic [1:0] eng_status
);
    assert_start_strobe_R3: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && ctrl_wdata[7:6] == 2'b10 && !ctrl_q[7]) |=> eng_valid);

    assert_busy_one_cycle_R3: assert property (@(posedge clk) disable iff (rst)
        ctrl_q[7] |=> !ctrl_q[7]);

    assert_valid_while_busy_R3: assert property (@(posedge clk) disable iff (rst)
        eng_valid |-> ctrl_q[7]);

    assert_status_code_R3: assert property (@(posedge clk) disable iff (rst)
        eng_valid |-> eng_status != 2'b11);

    assert_nodata_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (eng_valid && eng_status != 2'b00) |=> data_q == 8'h00);

    assert_ctrl_ignored_R2: assert property (@(posedge clk) disable iff (rst)
        (!(ctrl_wr && ctrl_wdata[7]) && !ctrl_q[7]) |=> $stable(ctrl_q));

    assert_fetch_no_strobe_R4: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && ctrl_wdata[7:6] == 2'b11 && !ctrl_q[7]) |=> !eng_valid);

endmodule

bind rtc_pram_ctrl rtc_pram_ctrl_chk chk_i (.*);

// File: tb/rtc_pram_ctrl_tb_top.sv
module rtc_pram_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       data_wr = 1'b0;
    logic [7:0] data_wdata = '0;
    logic       ctrl_wr = 1'b0;
    logic [7:0] ctrl_wdata = '0;
    logic [7:0] data_q, ctrl_q;
    logic       eng_valid;
    logic [1:0] eng_status;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    logic [7:0] mem [256];
    logic [7:0] sec [4];

    localparam logic [1:0] S_DATA = 2'b00, S_MORE = 2'b01, S_DONE = 2'b10;

    always #2 clk = ~clk;

    rtc_pram_ctrl dut_i (.*);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] b, output logic [1:0] st, output logic [7:0] res);
        @(negedge clk); data_wr = 1'b1; data_wdata = b;
        @(negedge clk); data_wr = 1'b0; ctrl_wr = 1'b1; ctrl_wdata = 8'h80;
        @(negedge clk); ctrl_wr = 1'b0;
        chk(eng_valid === 1'b1 && ctrl_q === 8'h80, "R3 strobe and busy", {eng_valid, ctrl_q}, 9'h180);
        st = eng_status;
        @(negedge clk);
        res = data_q;
        chk(ctrl_q === 8'h00 && eng_valid === 1'b0, "R3 busy cleared", {eng_valid, ctrl_q}, 9'h000);
    endtask

    task automatic xfer_exp(input logic [7:0] b, input logic [1:0] est, input logic [7:0] eres, input string tag);
        logic [1:0] st;
        logic [7:0] res;
        xfer(b, st, res);
        chk(st === est && res === eres, tag, {st, res}, {est, eres});
    endtask

    task automatic ext_wr(input logic [7:0] a, input logic [7:0] d, input string tag);
        xfer_exp(8'h38 | {5'b0, a[7:5]}, S_MORE, 8'h00, tag);
        xfer_exp({1'b0, a[4:0], 2'b00}, S_MORE, 8'h00, tag);
        xfer_exp(d, S_DONE, 8'h00, tag);
    endtask

    task automatic ext_rd(input logic [7:0] a, input logic [7:0] e, input string tag);
        xfer_exp(8'hB8 | {5'b0, a[7:5]}, S_MORE, 8'h00, tag);
        xfer_exp({1'b0, a[4:0], 2'b00}, S_DATA, e, tag);
    endtask

    task automatic short_wr(input logic [7:0] c, input logic [7:0] d, input string tag);
        xfer_exp(c, S_MORE, 8'h00, tag);
        xfer_exp(d, S_DONE, 8'h00, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(ctrl_q === 8'h00 && data_q === 8'h00 && eng_valid === 1'b0, "R1 reset state",
            {eng_valid, ctrl_q, data_q}, 17'h0);

        // R2: control writes with bit 7 clear are ignored
        ctrl_wr = 1'b1; ctrl_wdata = 8'h40;
        @(negedge clk); ctrl_wr = 1'b0;
        chk(ctrl_q === 8'h00 && eng_valid === 1'b0, "R2 bit7 clear ignored", {eng_valid, ctrl_q}, 9'h0);
        ctrl_wr = 1'b1; ctrl_wdata = 8'h3F;
        @(negedge clk); ctrl_wr = 1'b0;
        chk(ctrl_q === 8'h00 && eng_valid === 1'b0, "R2 bit7 clear ignored", {eng_valid, ctrl_q}, 9'h0);

        // R4: fetch-direction start skips the engine
        data_wr = 1'b1; data_wdata = 8'h5A;
        @(negedge clk); data_wr = 1'b0; ctrl_wr = 1'b1; ctrl_wdata = 8'hC0;
        @(negedge clk); ctrl_wr = 1'b1; ctrl_wdata = 8'h80;
        chk(ctrl_q === 8'hC0 && eng_valid === 1'b0, "R4 no strobe", {eng_valid, ctrl_q}, 9'h0C0);
        // R2: start while busy is ignored
        @(negedge clk); ctrl_wr = 1'b0;
        chk(ctrl_q === 8'h40 && data_q === 8'h5A && eng_valid === 1'b0, "R4 R2 busy clears, data kept",
            {eng_valid, ctrl_q, data_q}, {1'b0, 8'h40, 8'h5A});

        // R9 R5: extended write and read of every RAM address
        for (int a = 0; a < 256; a++) begin
            mem[a] = 8'((a * 37 + 11) ^ (a >> 3));
            ext_wr(8'(a), mem[a], "R9 R5 extended write");
        end
        for (int a = 0; a < 256; a++) ext_rd(8'(a), mem[a], "R9 extended read");

        // R8: short RAM 0x00-0x0F
        for (int a = 0; a < 16; a++) begin
            xfer_exp(8'hC0 | 8'(a << 2), S_DATA, mem[a], "R8 short read");
            mem[a] = ~mem[a];
            short_wr(8'h40 | 8'(a << 2), mem[a], "R8 R5 short write");
            ext_rd(8'(a), mem[a], "R8 short write visible");
        end

        // R7: short RAM 0x10-0x13
        for (int k = 0; k < 4; k++) begin
            xfer_exp(8'hA0 | 8'(k << 2), S_DATA, mem[16 + k], "R7 short read");
            mem[16 + k] = 8'(8'hE0 + k);
            short_wr(8'h20 | 8'(k << 2), mem[16 + k], "R7 short write");
            ext_rd(8'(16 + k), mem[16 + k], "R7 write visible");
        end

        // R6: seconds bytes, separate from RAM
        for (int k = 0; k < 4; k++) begin
            sec[k] = 8'(8'h91 + 17 * k);
            short_wr(8'(k << 2), sec[k], "R6 seconds write");
        end
        for (int k = 0; k < 4; k++) begin
            xfer_exp(8'h80 | 8'(k << 2), S_DATA, sec[k], "R6 seconds read");
            ext_rd(8'(k), mem[k], "R6 RAM untouched");
        end

        // R12: unrecognised group, both directions
        for (int c = 0; c < 16; c++) begin
            xfer_exp(8'h10 | 8'(c), S_DONE, 8'h00, "R12 unrecognised write dir");
            xfer_exp(8'h90 | 8'(c), S_DONE, 8'h00, "R12 unrecognised read dir");
        end
        xfer_exp(8'hC8, S_DATA, mem[2], "R12 back in command phase");

        // R11: write-only registers
        xfer_exp(8'hB4, S_DONE, 8'h00, "R11 lock read");
        xfer_exp(8'hB0, S_DONE, 8'h00, "R11 test read");
        short_wr(8'h30, 8'hFF, "R11 test write");
        xfer_exp(8'hC4, S_DATA, mem[1], "R11 command phase after test write");

        // R10: malformed second address byte
        xfer_exp(8'h38, S_MORE, 8'h00, "R10 ext write start");
        xfer_exp(8'h81, S_DONE, 8'h00, "R10 bad second byte bit7");
        xfer_exp(8'hCC, S_DATA, mem[3], "R10 command phase after abort");
        xfer_exp(8'hB9, S_MORE, 8'h00, "R10 ext read start");
        xfer_exp(8'h02, S_DONE, 8'h00, "R10 bad second byte bit1");
        xfer_exp(8'hB8, S_MORE, 8'h00, "R10 ext read start");
        xfer_exp(8'h01, S_DONE, 8'h00, "R10 bad second byte bit0");
        xfer_exp(8'hD0, S_DATA, mem[4], "R10 command phase after abort");

        // R13: write lock
        short_wr(8'h34, 8'h80, "R13 lock set");
        short_wr(8'h54, 8'h00, "R13 locked short write");
        xfer_exp(8'hD4, S_DATA, mem[5], "R13 locked RAM unchanged");
        ext_wr(8'hA7, 8'h00, "R13 locked ext write");
        ext_rd(8'hA7, mem[8'hA7], "R13 locked ext RAM unchanged");
        short_wr(8'h04, 8'h00, "R13 locked seconds write");
        xfer_exp(8'h84, S_DATA, sec[1], "R13 locked seconds unchanged");
        short_wr(8'h34, 8'h00, "R13 lock register writable while locked");
        mem[5] = 8'h3C;
        short_wr(8'h54, mem[5], "R13 unlocked write");
        xfer_exp(8'hD4, S_DATA, mem[5], "R13 unlocked write visible");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule